// File: doc/BRIEF.md
# DPI video timing generator

This block produces the raster timing for a parallel RGB panel: a horizontal sync, a vertical sync and a data-enable strobe. It also gives the pixel coordinates of the active area, counted from the first visible pixel. Horizontal and vertical timing each come from one packed 32-bit word that holds the sync width, the back porch and the front porch. A separate packed word holds the visible width and height. All of these are treated as quasi-static while the block is enabled.

Every line runs through four phases: sync, back porch, active pixels, front porch. Every frame runs through the same four phases, counted in lines. For an interrupt unit the block raises three signals: a one-cycle pulse at the start of each frame, a one-cycle error pulse when the upstream pixel pipeline has no data for an active pixel, and a static flag that marks a vertical sync plus back porch too short to give the pipeline time to prefetch.

Top module: `dpi_timing_gen`

## Requirements
- R1: The horizontal timing word holds the sync width in bits [7:0], the back porch in bits [19:8] and the front porch in bits [31:20], all in pixel clocks. A line lasts sync + back porch + width + front porch clocks, and `hsync` is high during its first sync-width clocks.
- R2: The vertical timing word uses the same bit positions for the vertical sync, back porch and front porch, counted in lines. A frame lasts sync + back porch + height + front porch lines, and `vsync` is high for all clocks of its first sync lines.
- R3: The panel-size word holds the visible width in bits [15:0] and the visible height in bits [31:16].
- R4: `de` is high only when the line position is in the active phase and the frame position is in the active phase. While `de` is high, `px_x` and `px_y` give the offset from the first active pixel and the first active line. Outside the active area both are 0.
- R5: `vsync_evt` is high for exactly the one clock at which the line position and the frame position are both 0, so it pulses once per frame.
- R6: `underflow_evt` is high in the clock after a clock in which `de` was high and `pix_valid` was low. It is low at all other times.
- R7: `vbp_risk` is high exactly when the vertical sync plus the vertical back porch is less than 32 lines. It follows the register values combinationally, whether or not the block is enabled.
- R8: While `enable` is low, the line and frame positions are held at 0 and `hsync`, `vsync`, `de`, `vsync_evt` and `underflow_evt` are low, with `px_x` and `px_y` at 0. When `enable` rises, a new frame starts at position (0, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the raster when high; holds it at the origin when low |
| h_timing | input | 32 | Packed horizontal sync, back porch and front porch |
| v_timing | input | 32 | Packed vertical sync, back porch and front porch |
| panel_size | input | 32 | Packed visible height and width |
| pix_valid | input | 1 | Upstream pixel available in this clock |
| hsync | output | 1 | Horizontal sync (active high by default) |
| vsync | output | 1 | Vertical sync (active high by default) |
| de | output | 1 | Data enable for the active area |
| px_x | output | 16 | Column inside the active area |
| px_y | output | 16 | Row inside the active area |
| vsync_evt | output | 1 | One-clock pulse at the start of each frame |
| underflow_evt | output | 1 | One-clock pulse after an active pixel with no data |
| vbp_risk | output | 1 | Vertical sync plus back porch is under 32 lines |

## Verification
Assertions check on every cycle the properties that hold whatever the configuration:
- each position counter stays below its period and falls to zero once disabled;
- the column stays inside the width while `de` is high and steps by one along a line;
- every underflow pulse has an active, data-less pixel one clock earlier;
- the frame pulse falls inside vertical sync.

Only the bench's scenarios can show that the exact phase boundaries match the packed field values. The same holds for the frame period, for restarting at the origin after a mid-frame disable, and for the flag boundary at 31 and 32 lines. The bench shows these by running its reference raster model against the outputs on every clock, under several timing words and pixel-valid patterns.

// File: rtl/dpi_timing_pkg.sv
// Package: field widths and bit positions of the packed timing words, the
// per-axis configuration type, and its unpacking function.
// Assumes 32-bit timing and panel-size words.
package dpi_timing_pkg;
    localparam int SYNC_W  = 8;              // sync width field
    localparam int PORCH_W = 12;             // porch field width
    localparam int ACT_W   = 16;             // visible size field width
    localparam int BP_LSB  = SYNC_W;         // back porch lowest bit
    localparam int FP_LSB  = SYNC_W + PORCH_W; // front porch lowest bit
    localparam int CNT_W   = ACT_W + 2;      // holds the largest period

    typedef struct packed {
        logic [ACT_W-1:0]   act;
        logic [PORCH_W-1:0] fp;
        logic [PORCH_W-1:0] bp;
        logic [SYNC_W-1:0]  sync;
    } axis_cfg_t;

    // Build one axis configuration from a timing word and a visible size.
    function automatic axis_cfg_t unpack_axis(input logic [31:0] tim,
                                              input logic [ACT_W-1:0] act);
        axis_cfg_t c;
        c.sync = tim[SYNC_W-1:0];
        c.bp   = tim[BP_LSB +: PORCH_W];
        c.fp   = tim[FP_LSB +: PORCH_W];
        c.act  = act;
        return c;
    endfunction
endpackage

// File: rtl/dpi_axis_counter.sv
// Module: position counter for one raster axis (pixels in a line or lines in
// a frame). It advances on 'step' and wraps after the last position of the
// period, where period = sync + back porch + active + front porch. It decodes
// the sync and active phases and the offset inside the active phase.
// Assumes the configuration is stable while 'en' is high.
module dpi_axis_counter
    import dpi_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             in_sync,
    output logic             in_act,
    output logic [ACT_W-1:0] pos
);
    logic [CNT_W-1:0] act_start;
    logic [CNT_W-1:0] act_end;
    logic [CNT_W-1:0] total;
    logic             last;

    // Phase boundaries derived from the field values.
    always_comb begin
        act_start = CNT_W'(cfg.sync) + CNT_W'(cfg.bp);
        act_end   = act_start + CNT_W'(cfg.act);
        total     = act_end + CNT_W'(cfg.fp);
    end

    // Phase decode for the current position.
    always_comb begin
        last    = (total == '0) || (cnt >= total - 1'b1);
        wrap    = step && last;
        in_sync = cnt < CNT_W'(cfg.sync);
        in_act  = (cnt >= act_start) && (cnt < act_end);
        pos     = in_act ? ACT_W'(cnt - act_start) : '0;
    end

    // Position register: cleared when disabled, wraps at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // R8: the position is zero in the cycle after the block is disabled
    a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    // R1 / R2: the position never leaves the configured period
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (total != '0) |-> (cnt < total));
endmodule

// File: rtl/dpi_frame_events.sv
// Module: interrupt-side signals. It makes the start-of-frame pulse, a
// registered underflow pulse, and the short-blanking configuration flag.
// Assumes 'de' comes from the same raster it guards.
module dpi_frame_events
    import dpi_timing_pkg::*;
#(
    parameter int RISK_LINES = 32
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               at_origin,
    input  logic               de,
    input  logic               pix_valid,
    input  logic [SYNC_W-1:0]  vs_len,
    input  logic [PORCH_W-1:0] vbp_len,
    output logic               vsync_evt,
    output logic               underflow_evt
,
    output logic               vbp_risk
);
    localparam int SUM_W = PORCH_W + 1;

    logic             starved_q;
    logic [SUM_W-1:0] blank_sum;

    // Records an active pixel that had no data behind it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            starved_q <= 1'b0;
        else
            starved_q <= de && !pix_valid;
    end

    // Event outputs and the configuration flag.
    always_comb begin
        vsync_evt     = en && at_origin;
        underflow_evt = en && starved_q;
        blank_sum     = SUM_W'(vs_len) + SUM_W'(vbp_len);
        vbp_risk      = blank_sum < SUM_W'(RISK_LINES);
    end

    // R6: every underflow pulse has a data-less active pixel one clock before
    a_r6_uf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_evt |-> $past(de && !pix_valid));
endmodule

// File: rtl/dpi_timing_gen.sv
// Module: top of the timing generator. It unpacks the timing and panel-size
// words, chains the horizontal counter into the vertical counter, and drives
// the sync, data-enable, coordinate and event outputs.
// Assumes the register words are quasi-static while 'enable' is high.
module dpi_timing_gen
    import dpi_timing_pkg::*;
#(
    parameter bit HS_HIGH    = 1'b1,
    parameter bit VS_HIGH    = 1'b1,
    parameter int RISK_LINES = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [31:0]      h_timing,
    input  logic [31:0]      v_timing,
    input  logic [31:0]      panel_size,
    input  logic             pix_valid,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [ACT_W-1:0] px_x,
    output logic [ACT_W-1:0] px_y,
    output logic             vsync_evt,
    output logic             underflow_evt,
    output logic             vbp_risk
);
    axis_cfg_t        h_cfg, v_cfg;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             h_wrap, v_wrap;
    logic             h_sync_ph, v_sync_ph;
    logic             h_act, v_act;
    logic [ACT_W-1:0] h_pos, v_pos;
    logic             hs_on, vs_on;

    // Split the packed words into per-axis configurations.
    always_comb begin
        h_cfg = unpack_axis(h_timing, panel_size[ACT_W-1:0]);
        v_cfg = unpack_axis(v_timing, panel_size[16 +: ACT_W]);
    end

    dpi_axis_counter u_hcnt (
        .clk(clk), .rst_n(rst_n), .en(enable), .step(1'b1), .cfg(h_cfg),
        .cnt(h_cnt), .wrap(h_wrap), .in_sync(h_sync_ph), .in_act(h_act),
        .pos(h_pos)
    );

    dpi_axis_counter u_vcnt (
        .clk(clk), .rst_n(rst_n), .en(enable), .step(h_wrap), .cfg(v_cfg),
        .cnt(v_cnt), .wrap(v_wrap), .in_sync(v_sync_ph), .in_act(v_act),
        .pos(v_pos)
    );

    // Sync, data-enable and coordinate outputs, all gated by enable.
    always_comb begin
        hs_on = enable && h_sync_ph;
        vs_on = enable && v_sync_ph;
        hsync = HS_HIGH ? hs_on : !hs_on;
        vsync = VS_HIGH ? vs_on : !vs_on;
        de    = enable && h_act && v_act;
        px_x  = de ? h_pos : '0;
        px_y  = de ? v_pos : '0;
    end

    dpi_frame_events #(.RISK_LINES(RISK_LINES)) u_evt (
        .clk(clk), .rst_n(rst_n), .en(enable),
        .at_origin((h_cnt == '0) && (v_cnt == '0)),
        .de(de), .pix_valid(pix_valid),
        .vs_len(v_cfg.sync), .vbp_len(v_cfg.bp),
        .vsync_evt(vsync_evt), .underflow_evt(underflow_evt),
        .vbp_risk(vbp_risk)
    );

    // R4: the column stays inside the visible width
    a_r4_de_x_bound: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (px_x < panel_size[ACT_W-1:0]));

    // R4: along one line the column advances by one per clock
    a_r4_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (de && $past(de) && px_x != '0) |-> (px_x == $past(px_x) + 1'b1));

    // R2 / R5: the frame pulse lies inside vertical sync when sync is nonzero
    a_r5_evt_in_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_evt && v_cfg.sync != '0) |-> (vsync == VS_HIGH));
endmodule

// File: tb/dpi_timing_gen_test.sv
module dpi_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        pix_valid = 1'b0;
    logic [31:0] h_timing = '0;
    logic [31:0] v_timing = '0;
    logic [31:0] panel_size = '0;
    logic        hsync, vsync, de, vsync_evt, underflow_evt, vbp_risk;
    logic [15:0] px_x, px_y;

    int hs, hbp, hfp, wid, vs, vbp, vfp, hgt;
    int hc, vc;
    bit uf_q;
    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    dpi_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .h_timing(h_timing), .v_timing(v_timing), .panel_size(panel_size),
        .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync), .de(de),
        .px_x(px_x), .px_y(px_y), .vsync_evt(vsync_evt),
        .underflow_evt(underflow_evt), .vbp_risk(vbp_risk)
    );

    task automatic cmp(input string tag, input string name, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d (hc=%0d vc=%0d)",
                     tag, name, act, exp, hc, vc);
        end
    endtask

    // Compare every output with the reference raster for the current state.
    task automatic check();
        bit h_a, v_a, de_e;
        string pre;
        pre  = enable ? "" : "R8 ";
        h_a  = (hc >= hs + hbp) && (hc < hs + hbp + wid);
        v_a  = (vc >= vs + vbp) && (vc < vs + vbp + hgt);
        de_e = enable && h_a && v_a;
        cmp({pre, "R1"}, "hsync", int'(hsync), int'(enable && hc < hs));
        cmp({pre, "R2"}, "vsync", int'(vsync), int'(enable && vc < vs));
        cmp({pre, "R3 R4"}, "de", int'(de), int'(de_e));
        cmp({pre, "R3 R4"}, "px_x", int'(px_x), de_e ? hc - hs - hbp : 0);
        cmp({pre, "R3 R4"}, "px_y", int'(px_y), de_e ? vc - vs - vbp : 0);
        cmp({pre, "R5"}, "vsync_evt", int'(vsync_evt), int'(enable && hc == 0 && vc == 0));
        cmp({pre, "R6"}, "underflow_evt", int'(underflow_evt), int'(enable && uf_q));
        cmp("R7", "vbp_risk", int'(vbp_risk), int'(vs + vbp < 32));
    endtask

    // Advance the reference by one clock using the inputs just applied.
    task automatic model_adv();
        bit h_a, v_a;
        h_a  = (hc >= hs + hbp) && (hc < hs + hbp + wid);
        v_a  = (vc >= vs + vbp) && (vc < vs + vbp + hgt);
        uf_q = enable && h_a && v_a && !pix_valid;
        if (!enable) begin
            hc = 0; vc = 0;
        end else begin
            hc++;
            if (hc >= hs + hbp + wid + hfp) begin
                hc = 0; vc++;
                if (vc >= vs + vbp + hgt + vfp) vc = 0;
            end
        end
    endtask

    task automatic step(input bit en_n, input bit pv_n);
        @(negedge clk);
        check();
        enable = en_n;
        pix_valid = pv_n;
        model_adv();
    endtask

    // mode 0: data always present; mode 1: pseudo-random data gaps
    task automatic run(input int n, input bit en_n, input int mode);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(en_n, mode == 0 ? 1'b1 : (lfsr[0] | lfsr[3]));
        end
    endtask

    // Called only while disabled, right after a negedge.
    task automatic configure(input int a, input int b, input int c, input int w,
                             input int d, input int e, input int f, input int h);
        hs = a; hbp = b; hfp = c; wid = w; vs = d; vbp = e; vfp = f; hgt = h;
        h_timing   = 32'((hfp << 20) | (hbp << 8) | hs);
        v_timing   = 32'((vfp << 20) | (vbp << 8) | vs);
        panel_size = 32'((hgt << 16) | wid);
    endtask

    initial begin
        configure(0, 0, 0, 0, 0, 0, 0, 0);
        hc = 0; vc = 0; uf_q = 0;
        repeat (3) @(negedge clk);
        check();                       // reset state, R8 and R7
        rst_n = 1'b1;
        run(4, 1'b0, 0);               // R8: idle after reset
        configure(2, 3, 2, 5, 1, 2, 1, 3);
        run(200, 1'b1, 0);             // R1 R2 R4 R5: data always present
        run(200, 1'b1, 1);             // R6: data gaps
        run(6, 1'b0, 1);               // R8: disable mid-frame
        run(100, 1'b1, 0);             // R8: restart at the origin
        run(2, 1'b0, 0);
        configure(3, 28, 1, 4, 4, 28, 1, 2);
        #1 cmp("R7", "vbp_risk at 32 lines", int'(vbp_risk), 0);
        configure(3, 27, 1, 4, 4, 27, 1, 2);
        #1 cmp("R7", "vbp_risk at 31 lines", int'(vbp_risk), 1);
        run(3, 1'b0, 0);               // R7 holds while disabled
        run(600, 1'b1, 1);
        run(2, 1'b0, 0);
        configure(3, 257, 256, 4, 1, 1, 1, 2);  // upper field bits, R1 R3
        run(2700, 1'b1, 1);
        run(3, 1'b0, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule